// File: doc/BRIEF.md
# Multi-Level Prioritized Interrupt Controller

This block gathers a set of interrupt lines into a pending register, gates that register with a software-owned enable register, and raises a single interrupt request toward a processor. Each line belongs to one of several priority levels. The controller reports the highest level that holds at least one pending, enabled line, provided that level is strictly above the processor's current interrupt threshold. The request and the reported level are registered outputs.

Every line is either level-type or edge-type. A level-type line's pending bit follows its input. An edge-type line latches on a rising input and holds until software clears it through a write-one-to-clear access. Timer compare-match pulses set the pending bit of the line assigned to each comparator. The line count, level count (up to 7), per-level line masks, per-line type vector and timer-to-line map are all parameters. A small register port reads and writes the pending, enable and threshold registers.

The request output is driven by a two-state machine. In QUIET the request is low. In REQUEST the request is high. The transitions are:
- WAKE (QUIET to REQUEST) when arbitration finds a qualifying level.
- DROP (REQUEST to QUIET) when no level qualifies.
- RETARGET (REQUEST to REQUEST) when a level still qualifies; the reported level is refreshed on this transition.
- HOLD (QUIET to QUIET) when nothing qualifies.

Top module: `prio_intc`

## Requirements
- R1: After reset the pending, enable and threshold registers are 0, the request is low and the reported level is 0.
- R2: Only lines set in both the pending and enable registers take part in arbitration. A pending line whose enable bit is 0 never causes a request.
- R3: Among the qualifying levels, the highest numbered level is reported.
- R4: A level equal to or below the threshold register is never reported. If the threshold is raised to or above the active level, the request drops.
- R5: When no level qualifies, the request is low and the reported level is 0.
- R6: A level-type line's pending bit is 1 while its input is 1 and 0 while its input is 0. A write-one-to-clear of that bit has no effect.
- R7: An edge-type line's pending bit is set by a 0-to-1 change of its input and stays set after the input returns to 0. Writing 1 to that bit at address 0 clears it. A rising input in the same cycle as the clear leaves the bit set.
- R8: Input bits at index NUM_LINES and above are ignored. They set no pending bit, read back as 0 and cause no request.
- R9: A one-cycle pulse on a timer match input sets the pending bit of the line mapped to that timer.
- R10: The pending register captures inputs on the first clock edge after they change. The request and level outputs reflect a pending, enable or threshold change on the next clock edge after it.
- R11: The register map is as follows.
  - Address 0 reads the pending register; a write to it clears edge-type bits.
  - Address 1 is the read/write enable register.
  - Address 2 is the read/write 3-bit threshold.
  - Address 3 reads 0.
  - Bits above the implemented width read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 32 | Interrupt line inputs; bits at NUM_LINES and above are ignored |
| timer_match | input | NUM_TIMERS | Timer compare-match pulses |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 3 | Level of the active request, 0 when none |

## Verification
An input change reaches the pending register after one clock edge and the request outputs after two. A register write (enable, threshold, or clear) reaches the outputs one edge after the edge that performs it. The bench drives every stimulus on a falling edge and counts falling edges before sampling. Pending is read back one falling edge after an input change, and the request and level two falling edges after it. For the latency requirement, the outputs are also sampled one edge early to confirm they have not yet moved.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
    localparam int LINE_SLOTS = 32;
    localparam int LVL_W      = 3;
    localparam int MAX_LEVELS = 7;
    localparam int MAP_W      = 5;

    typedef enum logic [1:0] {
        RA_PENDING = 2'd0,
        RA_ENABLE  = 2'd1,
        RA_THRESH  = 2'd2,
        RA_SPARE   = 2'd3
    } reg_addr_e;

    typedef enum logic {
        ST_QUIET   = 1'b0,
        ST_REQUEST = 1'b1
    } req_state_e;
endpackage

// File: rtl/intc_pending.sv
module intc_pending
    import prio_intc_pkg::*;
#(
    parameter int                           NUM_LINES   = 8,
    parameter logic [NUM_LINES-1:0]         EDGE_LINES  = 8'hAA,
    parameter int                           NUM_TIMERS  = 2,
    parameter logic [NUM_TIMERS*MAP_W-1:0]  TIMER_LINES = {5'd7, 5'd1}
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LINES-1:0]  line_in,
    input  logic [NUM_TIMERS-1:0] tmr_hit,
    input  logic [NUM_LINES-1:0]  clr_mask,
    output logic [NUM_LINES-1:0]  pend
);
    logic [NUM_LINES-1:0] prev_q;
    logic [NUM_LINES-1:0] tmr_vec;
    logic [NUM_LINES-1:0] pend_d;

    // route each comparator onto its configured line
    always_comb begin
        tmr_vec = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            for (int t = 0; t < NUM_TIMERS; t++) begin
                if (int'(TIMER_LINES[t*MAP_W +: MAP_W]) == i)
                    tmr_vec[i] = tmr_vec[i] | tmr_hit[t];
            end
        end
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        if (EDGE_LINES[i]) begin : g_edge
            assign pend_d[i] = (pend[i] & ~clr_mask[i])
                             | (line_in[i] & ~prev_q[i]) | tmr_vec[i];
        end else begin : g_lvl
            assign pend_d[i] = line_in[i] | tmr_vec[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend   <= '0;
            prev_q <= '0;
        end else begin
            pend   <= pend_d;
            prev_q <= line_in;
        end
    end

    // R6: level-type bits mirror the previous cycle's input
    a_r6_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((pend & ~EDGE_LINES) == ($past(line_in | tmr_vec) & ~EDGE_LINES)));

    // R7: an edge-type bit never falls without a clear
    a_r7_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((($past(pend & ~clr_mask) & EDGE_LINES) & ~pend) == '0));
endmodule

// File: rtl/intc_regs.sv
module intc_regs
    import prio_intc_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [1:0]            addr,
    input  logic [LINE_SLOTS-1:0] wdata,
    input  logic [NUM_LINES-1:0]  pend,
    output logic [NUM_LINES-1:0]  en,
    output logic [LVL_W-1:0]      thresh,
    output logic [NUM_LINES-1:0]  clr_mask,
    output logic [LINE_SLOTS-1:0] rdata
);
    reg_addr_e sel;
    logic      unused_wdata;

    assign sel          = reg_addr_e'(addr);
    assign unused_wdata = ^wdata;
    assign clr_mask     = (we && sel == RA_PENDING) ? wdata[NUM_LINES-1:0] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en     <= '0;
            thresh <= '0;
        end else if (we) begin
            if (sel == RA_ENABLE) en     <= wdata[NUM_LINES-1:0];
            if (sel == RA_THRESH) thresh <= wdata[LVL_W-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        unique case (sel)
            RA_PENDING: rdata[NUM_LINES-1:0] = pend;
            RA_ENABLE:  rdata[NUM_LINES-1:0] = en;
            RA_THRESH:  rdata[LVL_W-1:0]     = thresh;
            RA_SPARE:   rdata                = '0;
        endcase
    end

    // R11: a threshold write is visible on the next cycle
    a_r11_thresh_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == RA_THRESH) |=> (thresh == $past(wdata[LVL_W-1:0])));
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
    import prio_intc_pkg::*;
#(
    parameter int                              NUM_LINES   = 8,
    parameter int                              NUM_LEVELS  = 3,
    parameter logic [NUM_LEVELS*NUM_LINES-1:0] LEVEL_MASKS = 24'hC0_38_07
) (
    input  logic [NUM_LINES-1:0] eff,
    input  logic [LVL_W-1:0]     thresh,
    output logic                 found,
    output logic [LVL_W-1:0]     level
);
    logic [NUM_LEVELS:1] hit;

    for (genvar l = 1; l <= NUM_LEVELS; l++) begin : g_lvl
        assign hit[l] = (l > int'(thresh))
                      && |(LEVEL_MASKS[(l-1)*NUM_LINES +: NUM_LINES] & eff);
    end

    // ascending walk: the last hit is the highest qualifying level
    always_comb begin
        found = 1'b0;
        level = '0;
        for (int l = 1; l <= NUM_LEVELS; l++) begin
            if (hit[l]) begin
                found = 1'b1;
                level = LVL_W'(l);
            end
        end
    end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import prio_intc_pkg::*;
#(
    parameter int                              NUM_LINES   = 8,
    parameter int                              NUM_LEVELS  = 3,
    parameter logic [NUM_LEVELS*NUM_LINES-1:0] LEVEL_MASKS = 24'hC0_38_07,
    parameter logic [NUM_LINES-1:0]            EDGE_LINES  = 8'hAA,
    parameter int                              NUM_TIMERS  = 2,
    parameter logic [NUM_TIMERS*MAP_W-1:0]     TIMER_LINES = {5'd7, 5'd1}
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [31:0]           irq_in,
    input  logic [NUM_TIMERS-1:0] timer_match,
    input  logic                  reg_we,
    input  logic [1:0]            reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    output logic                  irq_req,
    output logic [2:0]            irq_level
);
    logic [NUM_LINES-1:0] pend, en, clr_mask;
    logic [LVL_W-1:0]     thresh, arb_level;
    logic                 found;
    req_state_e           state_q, state_d;
    logic [LVL_W-1:0]     level_q;
    logic                 unused_spare;

    if (NUM_LINES < LINE_SLOTS) begin : g_spare
        assign unused_spare = ^irq_in[LINE_SLOTS-1:NUM_LINES];
    end else begin : g_full
        assign unused_spare = 1'b0;
    end

    intc_pending #(
        .NUM_LINES(NUM_LINES), .EDGE_LINES(EDGE_LINES),
        .NUM_TIMERS(NUM_TIMERS), .TIMER_LINES(TIMER_LINES)
    ) u_pending (
        .clk(clk), .rst_n(rst_n), .line_in(irq_in[NUM_LINES-1:0]),
        .tmr_hit(timer_match), .clr_mask(clr_mask), .pend(pend)
    );

    intc_regs #(.NUM_LINES(NUM_LINES)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .pend(pend), .en(en), .thresh(thresh),
        .clr_mask(clr_mask), .rdata(reg_rdata)
    );

    intc_arbiter #(
        .NUM_LINES(NUM_LINES), .NUM_LEVELS(NUM_LEVELS), .LEVEL_MASKS(LEVEL_MASKS)
    ) u_arb (
        .eff(pend & en), .thresh(thresh), .found(found), .level(arb_level)
    );

    // next-state: WAKE, DROP, RETARGET, HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:   if (found)  state_d = ST_REQUEST;
            ST_REQUEST: if (!found) state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    // output register: level refreshed on WAKE and RETARGET, zeroed on DROP
    always_ff @(posedge clk) begin
        if (!rst_n)                  level_q <= '0;
        else if (state_d == ST_REQUEST) level_q <= arb_level;
        else                         level_q <= '0;
    end

    assign irq_req   = (state_q == ST_REQUEST);
    assign irq_level = level_q;

    a_r4_above_threshold: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_level > $past(thresh)));
    a_r5_quiet_level_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (irq_level == '0));
    a_r3_level_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_level != '0 && int'(irq_level) <= NUM_LEVELS));
    a_r2_needs_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ($past(pend & en) != '0));
endmodule

// File: tb/test_prio_intc.sv
`timescale 1ns/1ps
module test_prio_intc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic [1:0]  timer_match = '0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_req;
    logic [2:0]  irq_level;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    prio_intc i_prio_intc (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .timer_match(timer_match),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_level(irq_level)
    );

    // default config: lines 0-2 level 1, 3-5 level 2, 6-7 level 3; odd lines edge-type
    function automatic int lvl_of(int i);
        return (i < 3) ? 1 : (i < 6) ? 2 : 3;
    endfunction

    function automatic int exp_level(logic [7:0] p, logic [7:0] e, int thr);
        for (int l = 3; l >= 1; l--) begin
            if (l <= thr) return 0;
            for (int i = 0; i < 8; i++)
                if (p[i] && e[i] && lvl_of(i) == l) return l;
        end
        return 0;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick(1);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.1 d = reg_rdata;
    endtask

    task automatic check_out(string req, int lvl);
        check(req, {31'd0, irq_req}, {31'd0, lvl != 0});
        check(req, {29'd0, irq_level}, lvl);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        check_out("R1", 0);
        rd(2'd0, v); check("R1 pending", v, 0);
        rd(2'd1, v); check("R1 enable", v, 0);
        rd(2'd2, v); check("R1 thresh", v, 0);

        // R2: pending but nothing enabled
        irq_in = 32'h0000_0055; tick(2);
        check_out("R2 disabled", 0);
        irq_in = 0; wr(2'd0, 32'hFF); tick(1);

        // R11 register map
        wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, v); check("R11 enable width", v, 32'hFF);
        rd(2'd3, v); check("R11 spare", v, 0);
        wr(2'd2, 32'hFFFF_FFFD); rd(2'd2, v); check("R11 thresh", v, 5);
        wr(2'd2, 0);
        tick(1);

        // R3 R4 R5 R6 sweep: every pattern against every threshold
        for (int thr = 0; thr < 4; thr++) begin
            wr(2'd2, thr);
            tick(1);
            for (int p = 0; p < 256; p++) begin
                irq_in = p;
                tick(1);
                rd(2'd0, v); check("R6 R7 capture", v, p);
                tick(1);
                check_out(thr == 0 ? "R3 sweep" : "R4 sweep", exp_level(p, 8'hFF, thr));
                irq_in = 0;
                wr(2'd0, 32'hFF);
                tick(1);
                check_out("R5 idle", 0);
            end
        end
        wr(2'd2, 0);

        // R2 sweep over enable with every line pending
        irq_in = 32'hFF; tick(1);
        for (int e = 0; e < 256; e++) begin
            wr(2'd1, e);
            tick(1);
            check_out("R2 enable sweep", exp_level(8'hFF, e, 0));
        end
        irq_in = 0; wr(2'd0, 32'hFF); wr(2'd1, 32'hFF); tick(1);

        // R10 latency from input, and R7 sticky edge line 3 (level 2)
        irq_in = 32'h08; tick(1);
        check_out("R10 early", 0);
        tick(1);
        check_out("R10 due", 2);
        irq_in = 0; tick(2);
        rd(2'd0, v); check("R7 sticky", v, 32'h08);
        check_out("R7 sticky", 2);
        // R4 threshold raised to active level drops; R10 one-edge latency
        wr(2'd2, 2);
        check_out("R10 thresh early", 2);
        tick(1);
        check_out("R4 thresh drop", 0);
        wr(2'd2, 0); tick(1);
        check_out("R4 thresh restore", 2);
        wr(2'd0, 32'h08);
        rd(2'd0, v); check("R7 cleared", v, 0);
        tick(1);
        check_out("R7 cleared", 0);

        // R7: rise in the same cycle as clear keeps the bit
        irq_in = 32'h20; reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h20;
        tick(1); reg_we = 1'b0;
        rd(2'd0, v); check("R7 set beats clear", v, 32'h20);
        irq_in = 0; wr(2'd0, 32'hFF); tick(1);

        // R6: clear has no effect on a level-type line
        irq_in = 32'h01; tick(1);
        wr(2'd0, 32'h01);
        rd(2'd0, v); check("R6 clear ignored", v, 32'h01);
        check_out("R6 clear ignored", 1);
        irq_in = 0; tick(1);
        rd(2'd0, v); check("R6 follows low", v, 0);
        tick(1);

        // R8: out-of-range inputs ignored
        irq_in = 32'hFFFF_FF00; tick(2);
        rd(2'd0, v); check("R8 ignored", v, 0);
        check_out("R8 ignored", 0);
        irq_in = 0; tick(1);

        // R9 timers: timer0 to line 1, timer1 to line 7
        timer_match = 2'b01; tick(1); timer_match = 0;
        rd(2'd0, v); check("R9 timer0", v, 32'h02);
        tick(1); check_out("R9 timer0", 1);
        timer_match = 2'b10; tick(1); timer_match = 0;
        rd(2'd0, v); check("R9 timer1", v, 32'h82);
        tick(1); check_out("R9 timer1", 3);
        wr(2'd0, 32'hFF); tick(1);
        check_out("R9 cleared", 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule